// File: doc/BRIEF.md
# Three-Mode Ones-Limiting Bus Encoder

This block lowers the number of logic-one bits driven onto an 8-bit data bus. For each accepted input word it counts the ones. If the ones are the majority, every bit is flipped. If the zeros are the majority, the word is sent as it is. On an exact tie it flips only one interleaved half of the bus: either the odd-numbered bit positions or the even-numbered ones, whichever half holds more ones.

The encoded word and a 2-bit side-band code naming the chosen transform are registered on the rising clock edge whenever the input is marked valid. A combinational decoder in the same block takes an encoded word and its code and applies the same inversion mask again, which restores the original word. The encoder output never carries more than half of its bits set.

Top module: `halfInvertCodec`

## Requirements
- R1: A synchronous active-high reset clears `encWord` and `encMode` to zero on the next rising edge.
- R2: When the accepted word has more than four ones, every bit is inverted and the code is 01 (for example 0xFE encodes to 0x01).
- R3: When the accepted word has fewer than four ones, it passes unchanged and the code is 00 (for example 0x01 stays 0x01).
- R4: When the accepted word has exactly four ones and the odd positions (bits 7, 5, 3, 1; mask 0xAA) hold more of them, only those positions are inverted and the code is 10 (0xA9 encodes to 0x03).
- R5: When the accepted word has exactly four ones and the even positions (bits 6, 4, 2, 0; mask 0x55) hold more of them, only those positions are inverted and the code is 11 (0x56 encodes to 0x03).
- R6: When both halves hold exactly two ones, odd-position inversion with code 10 is chosen (0xF0 encodes to 0x5A, 0xC3 to 0x69).
- R7: While `inValid` is low, `encWord` and `encMode` hold their values whatever `inWord` does.
- R8: A word presented with `inValid` high appears on `encWord`/`encMode` at the rising edge that samples it, one cycle of latency, and not before.
- R9: The decoder output `rxData` equals `rxWord` XOR the mask of `rxMode` (00: 0x00, 01: 0xFF, 10: 0xAA, 11: 0x55), so feeding it an encoded word and its code returns the original word for all 256 inputs.
- R10: The registered `encWord` never has more than four bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inWord` for encoding on this edge |
| inWord | input | 8 | Raw data word to encode |
| encWord | output | 8 | Registered encoded word |
| encMode | output | 2 | Registered transform code |
| rxWord | input | 8 | Encoded word to be decoded |
| rxMode | input | 2 | Transform code that came with `rxWord` |
| rxData | output | 8 | Restored data word (combinational) |

## Verification
Directed words separate the four transforms: 0xFE and 0x01 tell full inversion from pass-through, 0xA9 and 0x56 tell the odd-half from the even-half choice on a tie, and 0xF0 and 0xC3 show the 2/2 tie falls to the odd half. A hold scenario changes `inWord` with `inValid` low to show nothing is captured, and samples just before and after the capturing edge to pin the one-cycle latency. A sweep over all 256 values compares each code against a count-based model, confirms at most four ones on the output, and loops the encoded pair back through the decoder to recover the original.

// File: rtl/codecPkg.sv
package codecPkg;

  typedef enum logic [1:0] {
    CODE_NONE = 2'b00,
    CODE_FULL = 2'b01,
    CODE_ODD  = 2'b10,
    CODE_EVEN = 2'b11
  } codeT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;
    codeT mode;
  } strobeT;

endpackage

// File: rtl/maskGen.sv
module maskGen #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] mask
);
  import codecPkg::*;

  logic isFull, isOdd, isEven;

  assign isFull = (mode == CODE_FULL);
  assign isOdd  = (mode == CODE_ODD);
  assign isEven = (mode == CODE_EVEN);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i % 2 == 1) begin : g_oddPos
      assign mask[i] = isFull | isOdd;
    end else begin : g_evenPos
      assign mask[i] = isFull | isEven;
    end
  end

endmodule

// File: rtl/modeSelect.sv
module modeSelect #(
  parameter int WIDTH = 8
) (
  input  logic             inValid,
  input  logic [WIDTH-1:0] inWord,
  output codecPkg::strobeT ctrl
);
  import codecPkg::*;

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(WIDTH / 2);

  logic [CNT_W-1:0] totalOnes, oddOnes, evenOnes;

  always_comb begin
    oddOnes  = '0;
    evenOnes = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i % 2 == 1) oddOnes  = oddOnes  + CNT_W'(inWord[i]);
      else            evenOnes = evenOnes + CNT_W'(inWord[i]);
    end
    totalOnes = oddOnes + evenOnes;
  end

  always_comb begin
    ctrl.load = inValid;
    if (totalOnes > HALF_CNT)       ctrl.mode = CODE_FULL;
    else if (totalOnes < HALF_CNT)  ctrl.mode = CODE_NONE;
    else if (evenOnes > oddOnes)    ctrl.mode = CODE_EVEN;
    else                            ctrl.mode = CODE_ODD;
  end

endmodule

// File: rtl/encDatapath.sv
module encDatapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] inWord,
  input  codecPkg::strobeT ctrl,
  output logic [WIDTH-1:0] encWord,
  output logic [1:0]       encMode
);
  logic [WIDTH-1:0] flipMask;

  maskGen #(.WIDTH(WIDTH)) uMask (
    .mode (ctrl.mode),
    .mask (flipMask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      encWord <= '0;
      encMode <= '0;
    end else if (ctrl.load) begin
      encWord <= inWord ^ flipMask;
      encMode <= ctrl.mode;
    end
  end

endmodule

// File: rtl/invDecoder.sv
module invDecoder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rxWord,
  input  logic [1:0]       rxMode,
  output logic [WIDTH-1:0] rxData
);
  logic [WIDTH-1:0] undoMask;

  maskGen #(.WIDTH(WIDTH)) uMask (
    .mode (rxMode),
    .mask (undoMask)
  );

  assign rxData = rxWord ^ undoMask;

endmodule

// File: rtl/halfInvertCodec.sv
module halfInvertCodec #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inWord,
  output logic [WIDTH-1:0] encWord,
  output logic [1:0]       encMode,
  input  logic [WIDTH-1:0] rxWord,
  input  logic [1:0]       rxMode,
  output logic [WIDTH-1:0] rxData
);
  codecPkg::strobeT ctrl;

  modeSelect #(.WIDTH(WIDTH)) uCtrl (
    .inValid (inValid),
    .inWord  (inWord),
    .ctrl    (ctrl)
  );

  encDatapath #(.WIDTH(WIDTH)) uData (
    .clk     (clk),
    .rst     (rst),
    .inWord  (inWord),
    .ctrl    (ctrl),
    .encWord (encWord),
    .encMode (encMode)
  );

  invDecoder #(.WIDTH(WIDTH)) uDec (
    .rxWord (rxWord),
    .rxMode (rxMode),
    .rxData (rxData)
  );

endmodule

// File: rtl/codecChecker.sv
module codecChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [WIDTH-1:0] inWord,
  input logic [WIDTH-1:0] encWord,
  input logic [1:0]       encMode
);
  localparam int HALF = WIDTH / 2;

  function automatic logic [WIDTH-1:0] undoOf(input logic [1:0] m);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++)
      r[i] = (m == 2'b01) || (m == 2'b10 && i % 2 == 1) || (m == 2'b11 && i % 2 == 0);
    return r;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (encWord == '0 && encMode == 2'b00));

  p_full_invert_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && $countones(inWord) > HALF) |=> (encMode == 2'b01 && encWord == ~$past(inWord)));

  p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && $countones(inWord) < HALF) |=> (encMode == 2'b00 && encWord == $past(inWord)));

  p_tie_half_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && $countones(inWord) == HALF) |=> encMode[1]);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(encWord) && $stable(encMode)));

  p_roundtrip_r9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ((encWord ^ undoOf(encMode)) == $past(inWord)));

  p_ones_limit_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(encWord) <= HALF);

endmodule

bind halfInvertCodec codecChecker #(.WIDTH(WIDTH)) uChk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inWord  (inWord),
  .encWord (encWord),
  .encMode (encMode)
);

// File: tb/sim_halfInvertCodec.sv
module sim_halfInvertCodec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inWord = 8'h00;
  logic [7:0] encWord;
  logic [1:0] encMode;
  logic [7:0] rxWord = 8'h00;
  logic [1:0] rxMode = 2'b00;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  halfInvertCodec u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .encWord(encWord), .encMode(encMode),
    .rxWord(rxWord), .rxMode(rxMode), .rxData(rxData)
  );

  // model written from the requirements
  function automatic logic [1:0] expMode(input logic [7:0] w);
    int tot = $countones(w);
    int odd = $countones(w & 8'hAA);
    int even = $countones(w & 8'h55);
    if (tot > 4) return 2'b01;
    if (tot < 4) return 2'b00;
    if (even > odd) return 2'b11;
    return 2'b10;
  endfunction

  function automatic logic [7:0] maskFor(input logic [1:0] m);
    case (m)
      2'b01:   return 8'hFF;
      2'b10:   return 8'hAA;
      2'b11:   return 8'h55;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [7:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectWord(input logic [7:0] w, input logic [1:0] m, input logic [7:0] e, input string tag);
    sendWord(w);
    check(encMode == m, {tag, " mode"}, encMode, m);
    check(encWord == e, {tag, " word"}, encWord, e);
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    check(encWord == 8'h00, "R1 word at reset", encWord, 0);
    check(encMode == 2'b00, "R1 mode at reset", encMode, 0);
    rst = 1'b0;
    sendWord(8'hFE);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(encWord == 8'h00 && encMode == 2'b00, "R1 mid-run reset", {encMode, encWord}, 0);
    rst = 1'b0;
  endtask

  task automatic testExamples();
    expectWord(8'hFE, 2'b01, 8'h01, "R2 full");
    expectWord(8'h01, 2'b00, 8'h01, "R3 pass");
    expectWord(8'h00, 2'b00, 8'h00, "R3 zero");
    expectWord(8'hA9, 2'b10, 8'h03, "R4 odd half");
    expectWord(8'h56, 2'b11, 8'h03, "R5 even half");
    expectWord(8'hF0, 2'b10, 8'h5A, "R6 tie 2/2");
    expectWord(8'hC3, 2'b10, 8'h69, "R6 tie 2/2 b");
  endtask

  task automatic testHoldAndLatency();
    sendWord(8'hF0);
    @(negedge clk);
    inValid = 1'b0;
    inWord  = 8'hFF;
    repeat (3) @(negedge clk);
    check(encWord == 8'h5A && encMode == 2'b10, "R7 hold", {encMode, encWord}, {2'b10, 8'h5A});
    inValid = 1'b1;
    inWord  = 8'hFE;
    @(posedge clk);
    #0;
    @(negedge clk);
    inValid = 1'b0;
    check(encWord == 8'h01 && encMode == 2'b01, "R8 after edge", {encMode, encWord}, {2'b01, 8'h01});
    inValid = 1'b1;
    inWord  = 8'h01;
    #1;
    check(encWord == 8'h01 && encMode == 2'b01, "R8 before edge", {encMode, encWord}, {2'b01, 8'h01});
    @(posedge clk);
    #1;
    check(encMode == 2'b00, "R8 one cycle", encMode, 0);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testSweep();
    for (int v = 0; v < 256; v++) begin
      logic [1:0] m;
      m = expMode(8'(v));
      sendWord(8'(v));
      check(encMode == m, "R2/R3 sweep mode", encMode, m);
      check(encWord == (8'(v) ^ maskFor(m)), "R10 sweep word", encWord, 8'(v) ^ maskFor(m));
      check($countones(encWord) <= 4, "R10 ones limit", $countones(encWord), 4);
      rxWord = encWord;
      rxMode = encMode;
      #1;
      check(rxData == 8'(v), "R9 roundtrip", rxData, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testExamples();
    testHoldAndLatency();
    testSweep();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule